// File: doc/BRIEF.md
# 5B Symbol Aligner and Nibble Receive Framer

This block sits after a descrambler in a 100 Mb/s twisted-pair receive path. It takes a serial stream of descrambled bits with no known code-group boundary, one bit per cycle where `bit_vld` is high. It watches every bit position for a start delimiter: a run of idle ones, then the 5-bit code /J/ (11000) and then /K/ (10001). A match fixes the 5-bit boundary. From that point the block cuts the stream into symbols and turns each one into a 4-bit nibble. The nibbles go to a MAC-facing receive interface made of `rxd`, `rx_dv`, `rx_er` and a one-cycle `nib_stb` pulse for each nibble.

The delimiter pair itself is delivered as two preamble nibbles (0101). Data symbols follow. The end-of-stream pair /T/ (01101) then /R/ (00111) ends the frame, and neither of those two symbols is delivered. A frame is also cut short when `link_ok` or `sig_det` goes low. After either kind of ending the block hunts again at any bit offset. Symbols are assembled with the first received bit in the most significant position.

Top module: `rx_symbol_framer`

## Requirements
- R1: During reset and on the first cycle after it, `rx_dv`, `rx_er` and `nib_stb` are 0 and `rxd` is 4'b0000.
- R2: The block locks when the last bit of /K/ is accepted, provided the most recent 10+IDLE_BITS accepted bits are IDLE_BITS ones, then 11000, then 10001, with both lines up. On the next cycle `nib_stb` pulses with `rxd`=0101, and `rx_dv` rises together with that pulse.
- R3: A /J/K/ pattern that does not have at least IDLE_BITS consecutive ones right before it is ignored. No strobe is produced and `rx_dv` stays 0.
- R4: A locked frame delivers, in order, two preamble nibbles 0101 and then one nibble per received symbol. Each `nib_stb` pulse lasts one cycle. The nibble of a symbol is presented on the strobe that follows acceptance of the next symbol's last bit, so there is one symbol of latency. Strobes never come closer together than five accepted bits.
- R5: Data symbols decode as follows: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. `rxd[0]` is the least significant bit of the nibble.
- R6: A /T/ symbol followed directly by /R/ ends the frame. No nibble is delivered for either symbol, and `rx_dv` is 0 on the cycle after the last bit of /R/ is accepted.
- R7: A symbol inside a frame that is not a data code is delivered with `rx_er`=1 and `rxd`=0000 on its strobe. `rx_dv` stays 1 and decoding goes on. This covers a /T/ that is not followed by /R/.
- R8: If `link_ok` or `sig_det` is low during a frame, `rx_dv` and `rx_er` are 0 on the next cycle. No strobe follows until a new delimiter has been matched after both lines are up again.
- R9: After a frame ends or is aborted, a new idle run followed by /J/K/ locks again at any bit offset.
- R10: Cycles with `bit_vld` low do not change the decoded output, whatever value `bit_in` has on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | `bit_in` holds a new bit this cycle |
| bit_in | input | 1 | Descrambled serial bit |
| link_ok | input | 1 | Link status, high when the link is good |
| sig_det | input | 1 | Signal presence, high when a signal is detected |
| rxd | output | 4 | Decoded receive nibble, bit 0 is the LSB |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| nib_stb | output | 1 | One-cycle pulse marking a new nibble |

## Verification
The bench builds the block with the default IDLE_BITS=10. The prefix idle run is varied randomly between 10 and 17 ones, which places the delimiter at every one of the five symbol phases and checks locking at arbitrary offsets. With a 10-bit idle requirement, a short run of 5 ones ahead of /J/K/ is a direct rejection case. It can be built without any long preamble stretch. Random gaps in `bit_vld`, with garbage on `bit_in` during those gaps, run through every frame. Directed cases cover the exact strobe cycle on lock, link loss, signal loss with an error nibble pending, and a stray /T/.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int CNT_W = $clog2(SYM_W);

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } fr_state_e;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             bad;
        logic             is_t;
        logic             is_r;
    } sym_info_t;

    function automatic sym_info_t classify(input logic [SYM_W-1:0] s);
        sym_info_t r;
        r = '{nib: '0, bad: 1'b0, is_t: 1'b0, is_r: 1'b0};
        case (s)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            SYM_T: begin
                r.bad  = 1'b1;
                r.is_t = 1'b1;
            end
            SYM_R: begin
                r.bad  = 1'b1;
                r.is_r = 1'b1;
            end
            default: r.bad = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fr_delim_hunt.sv
module fr_delim_hunt
    import fr_pkg::*;
#(
    parameter int IDLE_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [SYM_W-1:0] cur_sym,
    output logic             jk_hit
);
    localparam int WIN = IDLE_BITS + 2 * SYM_W;
    localparam logic [WIN-1:0] PATTERN = {{IDLE_BITS{1'b1}}, SYM_J, SYM_K};

    logic [WIN-1:0] hist;
    logic [WIN-1:0] hist_nxt;

    assign hist_nxt = {hist[WIN-2:0], bit_in};
    assign cur_sym  = hist_nxt[SYM_W-1:0];
    assign jk_hit   = bit_vld && !flush && (hist_nxt == PATTERN);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist <= '0;
        end else if (bit_vld) begin
            hist <= hist_nxt;
        end
    end
endmodule

// File: rtl/fr_sym_decode.sv
module fr_sym_decode
    import fr_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_info_t        info
);
    assign info = classify(sym);
endmodule

// File: rtl/fr_frame_ctrl.sv
module fr_frame_ctrl
    import fr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_up,
    input  logic             bit_vld,
    input  logic             jk_hit,
    input  sym_info_t        info,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             nib_stb
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SYM_W - 1);

    fr_state_e        state;
    logic [CNT_W-1:0] bit_cnt;
    logic [NIB_W-1:0] pend_nib;
    logic             pend_bad;
    logic             pend_t;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            bit_cnt  <= '0;
            pend_nib <= '0;
            pend_bad <= 1'b0;
            pend_t   <= 1'b0;
            rxd      <= '0;
            rx_dv    <= 1'b0;
            rx_er    <= 1'b0;
            nib_stb  <= 1'b0;
        end else begin
            nib_stb <= 1'b0;
            if (!line_up) begin
                state <= ST_HUNT;
                rx_dv <= 1'b0;
                rx_er <= 1'b0;
            end else begin
                case (state)
                    ST_HUNT: begin
                        if (jk_hit) begin
                            state    <= ST_FRAME;
                            bit_cnt  <= '0;
                            rxd      <= NIB_PRE;
                            rx_dv    <= 1'b1;
                            rx_er    <= 1'b0;
                            nib_stb  <= 1'b1;
                            pend_nib <= NIB_PRE;
                            pend_bad <= 1'b0;
                            pend_t   <= 1'b0;
                        end
                    end
                    ST_FRAME: begin
                        if (bit_vld) begin
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                if (pend_t && info.is_r) begin
                                    state <= ST_HUNT;
                                    rx_dv <= 1'b0;
                                    rx_er <= 1'b0;
                                end else begin
                                    rxd      <= pend_bad ? '0 : pend_nib;
                                    rx_er    <= pend_bad;
                                    nib_stb  <= 1'b1;
                                    pend_nib <= info.nib;
                                    pend_bad <= info.bad;
                                    pend_t   <= info.is_t;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_symbol_framer.sv
module rx_symbol_framer
    import fr_pkg::*;
#(
    parameter int IDLE_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             link_ok,
    input  logic             sig_det,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             nib_stb
);
    logic             line_up;
    logic [SYM_W-1:0] cur_sym;
    logic             jk_hit;
    sym_info_t        info;

    assign line_up = link_ok && sig_det;

    fr_delim_hunt #(.IDLE_BITS(IDLE_BITS)) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .flush   (!line_up),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .cur_sym (cur_sym),
        .jk_hit  (jk_hit)
    );

    fr_sym_decode u_dec (
        .sym  (cur_sym),
        .info (info)
    );

    fr_frame_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .line_up (line_up),
        .bit_vld (bit_vld),
        .jk_hit  (jk_hit),
        .info    (info),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .nib_stb (nib_stb)
    );
endmodule

// File: rtl/rx_symbol_framer_chk.sv
module rx_symbol_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_vld,
    input logic       link_ok,
    input logic       sig_det,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       nib_stb
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!rx_dv && !rx_er && !nib_stb && rxd == 4'b0000));

    a_r2_dv_rises_with_preamble: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dv) |-> (nib_stb && rxd == 4'b0101 && !rx_er));

    a_r4_single_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        nib_stb |=> !nib_stb);

    a_r4_strobe_inside_frame: assert property (@(posedge clk) disable iff (rst)
        nib_stb |-> rx_dv);

    a_r10_strobe_needs_bit: assert property (@(posedge clk) disable iff (rst)
        nib_stb |-> $past(bit_vld));

    a_r7_error_inside_frame: assert property (@(posedge clk) disable iff (rst)
        rx_er |-> rx_dv);

    a_r8_line_loss_drops: assert property (@(posedge clk) disable iff (rst)
        (rx_dv && !(link_ok && sig_det)) |=> (!rx_dv && !rx_er && !nib_stb));
endmodule

bind rx_symbol_framer rx_symbol_framer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .link_ok (link_ok),
    .sig_det (sig_det),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .nib_stb (nib_stb)
);

// File: tb/rx_symbol_framer_bench.sv
module rx_symbol_framer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       link_ok = 1'b1;
    logic       sig_det = 1'b1;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;
    logic       nib_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [4:0] got_q[$];
    logic [4:0] exp_q[$];

    localparam logic [4:0] C_J = 5'b11000;
    localparam logic [4:0] C_K = 5'b10001;
    localparam logic [4:0] C_T = 5'b01101;
    localparam logic [4:0] C_R = 5'b00111;

    always #10 clk = ~clk;

    rx_symbol_framer u_rx_symbol_framer (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .link_ok(link_ok), .sig_det(sig_det),
        .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .nib_stb(nib_stb)
    );

    always @(negedge clk) begin
        if (!rst && nib_stb) got_q.push_back({rx_er, rxd});
    end

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [4:0] bad_code(input int k);
        case (k % 6)
            0: return 5'b00000;  1: return 5'b00001;
            2: return 5'b00010;  3: return 5'b00100;
            4: return 5'b01000;  default: return 5'b11001;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int gap);
        @(negedge clk);
        bit_in = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in = 1'($urandom & 1);
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_sym(input logic [4:0] s, input int maxgap);
        for (int i = 4; i >= 0; i--)
            drive_bit(s[i], (maxgap == 0) ? 0 : int'($urandom % (maxgap + 1)));
    endtask

    task automatic send_ones(input int n, input int maxgap);
        for (int i = 0; i < n; i++)
            drive_bit(1'b1, (maxgap == 0) ? 0 : int'($urandom % (maxgap + 1)));
    endtask

    task automatic compare_frame(input string req);
        check(req, "nibble count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(req, $sformatf("nibble %0d {er,rxd}", i), got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic run_frame(input int ndata, input int maxgap, input bit with_bad);
        send_ones(10 + int'($urandom % 8), maxgap);
        send_sym(C_J, maxgap);
        send_sym(C_K, maxgap);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00101);
        for (int i = 0; i < ndata; i++) begin
            if (with_bad && ($urandom % 4 == 0)) begin
                send_sym(bad_code(int'($urandom % 6)), maxgap);
                exp_q.push_back(5'b10000);
            end else begin
                logic [3:0] n;
                n = 4'($urandom);
                send_sym(enc(n), maxgap);
                exp_q.push_back({1'b0, n});
            end
        end
        send_sym(C_T, maxgap);
        send_sym(C_R, maxgap);
        send_ones(6, maxgap);
        check("R6", "rx_dv after end pair", rx_dv, 1'b0);
        compare_frame("R9 R4 R7 R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F00D5));
        repeat (3) @(negedge clk);
        check("R1", "rx_dv in reset", rx_dv, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rx_dv", rx_dv, 1'b0);
        check("R1", "rx_er", rx_er, 1'b0);
        check("R1", "nib_stb", nib_stb, 1'b0);
        check("R1", "rxd", rxd, 4'h0);

        // R2, R5: directed frame, no gaps, exact lock cycle
        send_ones(12, 0);
        send_sym(C_J, 0);
        for (int i = 4; i >= 1; i--) drive_bit(C_K[i], 0);
        check("R2", "rx_dv before K done", rx_dv, 1'b0);
        drive_bit(C_K[0], 0);
        check("R2", "nib_stb on lock", nib_stb, 1'b1);
        check("R2", "rxd on lock", rxd, 4'b0101);
        check("R2", "rx_dv on lock", rx_dv, 1'b1);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00101);
        begin
            logic [3:0] dl[4] = '{4'h1, 4'h8, 4'hA, 4'hF};
            foreach (dl[i]) begin
                send_sym(enc(dl[i]), 0);
                exp_q.push_back({1'b0, dl[i]});
            end
        end
        send_sym(C_T, 0);
        for (int i = 4; i >= 0; i--) drive_bit(C_R[i], 0);
        check("R6", "rx_dv cycle after R", rx_dv, 1'b0);
        send_ones(4, 0);
        compare_frame("R5 R4");

        // R3: delimiter after too short an idle run
        for (int i = 0; i < 5; i++) drive_bit(1'b0, 0);
        send_ones(5, 1);
        send_sym(C_J, 1);
        send_sym(C_K, 1);
        for (int i = 0; i < 10; i++) drive_bit(1'b0, 1);
        check("R3", "rx_dv", rx_dv, 1'b0);
        check("R3", "strobes seen", got_q.size(), 0);
        got_q.delete();

        // R8: link loss mid-frame
        send_ones(11, 0);
        send_sym(C_J, 0);
        send_sym(C_K, 0);
        send_sym(enc(4'h2), 0);
        send_sym(enc(4'h5), 0);
        send_sym(enc(4'h7), 0);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00010);
        exp_q.push_back(5'b00101);
        link_ok = 1'b0;
        @(negedge clk);
        check("R8", "rx_dv after link loss", rx_dv, 1'b0);
        send_sym(enc(4'h3), 0);
        send_sym(enc(4'h4), 0);
        link_ok = 1'b1;
        send_sym(enc(4'h9), 0);
        send_ones(3, 0);
        check("R8", "rx_dv after link back", rx_dv, 1'b0);
        compare_frame("R8");

        // R8, R7: signal loss with an error nibble on the output
        send_ones(13, 1);
        send_sym(C_J, 1);
        send_sym(C_K, 1);
        send_sym(bad_code(0), 1);
        send_sym(enc(4'hC), 1);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b10000);
        check("R7", "rx_er on bad symbol", rx_er, 1'b1);
        check("R7", "rx_dv held", rx_dv, 1'b1);
        sig_det = 1'b0;
        @(negedge clk);
        check("R8", "rx_dv after signal loss", rx_dv, 1'b0);
        check("R8", "rx_er after signal loss", rx_er, 1'b0);
        send_sym(enc(4'h6), 0);
        sig_det = 1'b1;
        send_ones(2, 0);
        compare_frame("R8 R7");

        // R7: stray T not followed by R
        send_ones(10, 0);
        send_sym(C_J, 0);
        send_sym(C_K, 0);
        send_sym(C_T, 0);
        send_sym(enc(4'hB), 0);
        send_sym(C_T, 0);
        send_sym(C_R, 0);
        send_ones(3, 0);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b00101);
        exp_q.push_back(5'b10000);
        exp_q.push_back(5'b01011);
        check("R6", "rx_dv after stray T frame", rx_dv, 1'b0);
        compare_frame("R7 stray T");

        // R9, R10: random frames at varied offsets with gaps
        for (int f = 0; f < 10; f++)
            run_frame(4 + int'($urandom % 12), (f % 3), (f % 2) == 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule